// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes written by software into asynchronous serial frames. A write puts the byte into a one-entry holding buffer. When the shift stage is free, the buffer contents move into it and the frame goes out on the transmit line. Each bit lasts sixteen pulses of an external 16x baud tick.

The character format is sampled at the moment of that transfer:
- seven, eight or nine data bits;
- an optional odd, even, mark or space parity bit;
- one or two stop bits;
- an optional shortened final stop bit.

A loopback code sends the internal transmit line to the receiver input instead of the pin. The block reports an empty-buffer flag and a busy flag. It raises an interrupt request while the buffer is empty and the interrupt is enabled.

Top module: `async_tx`

## Requirements
- R1: After a synchronous reset, `buf_empty` is 1, `sending` is 0 and `txd` is 1. `buf_empty` becomes 0 the cycle after a write. It becomes 1 again the cycle after the buffer contents transfer to the shift stage.
- R2: The transmit line idles high. A frame is one low start bit, then the data bits least significant first, then the parity bit if any, then the stop bits (high). Every bit except a shortened final stop bit lasts 16 baud ticks. Format and data are sampled in the transfer cycle.
- R3: `cfg_len` selects the character length: 00 gives eight data bits, 01 gives seven (bits 6..0 of the byte), 10 gives nine.
- R4: In nine-bit framing, `cfg_bit9_par_lo`, sampled at transfer, is sent as the ninth data bit after bit 7 of the byte. No parity bit is sent, whatever `cfg_par_en` holds.
- R5: In seven- and eight-bit framing with `cfg_par_en`=1, a parity bit follows the data. The code {`cfg_par_hi`,`cfg_bit9_par_lo`} selects it:
  - 00 odd: data bits plus parity have an odd count of ones;
  - 01 even;
  - 10 mark: always 1;
  - 11 space: always 0.
- R6: `sending` rises the cycle after a transfer. It stays high until the final tick of the last stop bit of the last queued frame, and falls the cycle after that tick.
- R7: `cfg_two_stop`=0 sends one stop bit; 1 sends two.
- R8: With `cfg_short_stop`=1, the final stop bit lasts 14 ticks instead of 16.
- R9: If the buffer is full when a frame's final tick arrives, the next start bit begins the very next cycle, with no idle gap.
- R10: If a write lands in the same cycle as a transfer, two things happen. The shift stage takes the older byte. The buffer keeps the new byte, so `buf_empty` stays 0.
- R11: `cfg_len`=11 uses nine-bit framing. It holds `txd` at 1 and drives `rx_to_rcvr` from the internal transmit line. For other codes, `rx_to_rcvr` follows `rx_pin`.
- R12: `tx_irq` is 1 exactly when `irq_en` is 1 and `buf_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte written to the holding buffer |
| cfg_len | input | 2 | Character length / loopback code |
| cfg_par_en | input | 1 | Parity enable (7/8-bit framing) |
| cfg_par_hi | input | 1 | High bit of the parity code |
| cfg_bit9_par_lo | input | 1 | Ninth data bit, or low bit of the parity code |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_short_stop | input | 1 | Final stop bit shortened to 14 ticks |
| irq_en | input | 1 | Transmit interrupt enable |
| rx_pin | input | 1 | External receive line |
| txd | output | 1 | Serial transmit line |
| rx_to_rcvr | output | 1 | Line presented to the receiver |
| buf_empty | output | 1 | Holding buffer empty |
| sending | output | 1 | Frame in progress |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The collision of interest is a software write arriving in the very cycle the buffer empties into the shift stage. It is provoked in two ways:
- two writes in consecutive cycles while the line is idle, so the second write meets the transfer the first one triggers;
- a write issued mid-frame, so the buffer is still full when the frame's final tick arrives.

Both are judged against a behavioural model that queues bits and counts ticks. The model predicts the line, the flags and the interrupt on every clock. A lost byte, a duplicated byte, a one-cycle idle gap or a wrongly set empty flag all show up as a miscompare.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int SHORT_TICKS   = 14;
    localparam int MAX_DATA      = 9;
    localparam int BYTE_W        = 8;
    localparam int FRAME_W       = 1 + MAX_DATA + 1 + 2;
    localparam int CNT_W         = $clog2(TICKS_PER_BIT);
    localparam int LEN_W         = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        LEN8      = 2'b00,
        LEN7      = 2'b01,
        LEN9      = 2'b10,
        LEN9_LOOP = 2'b11
    } char_len_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_kind_e;

    typedef struct packed {
        char_len_e len;
        logic      par_en;
        logic      par_hi;
        logic      bit9_or_par_lo;
        logic      two_stop;
        logic      short_stop;
    } tx_cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   nbits;
        logic               short_last;
    } frame_t;

    function automatic frame_t build_frame(tx_cfg_t cfg, logic [BYTE_W-1:0] data);
        frame_t            f;
        logic [MAX_DATA-1:0] d;
        int                nd;
        logic              par_on;
        logic              x;
        logic              p;
        d      = {cfg.bit9_or_par_lo, data};
        nd     = (cfg.len == LEN7) ? 7 : (cfg.len[1] ? 9 : 8);
        par_on = cfg.par_en && !cfg.len[1];
        x      = ^(data & ((nd == 7) ? 8'h7F : 8'hFF));
        case (par_kind_e'({cfg.par_hi, cfg.bit9_or_par_lo}))
            PAR_ODD:  p = ~x;
            PAR_EVEN: p = x;
            PAR_MARK: p = 1'b1;
            default:  p = 1'b0;
        endcase
        f.bits    = '1;
        f.bits[0] = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < nd) f.bits[1+i] = d[i];
        end
        if (par_on) f.bits[1+nd] = p;
        f.nbits      = LEN_W'(1 + nd + (par_on ? 1 : 0) + (cfg.two_stop ? 2 : 1));
        f.short_last = cfg.short_stop;
        return f;
    endfunction

endpackage

// File: rtl/tx_holding.sv
module tx_holding
    import async_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              load,
    output logic              buf_full,
    output logic [BYTE_W-1:0] buf_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_full <= 1'b0;
            buf_data <= '0;
        end else if (wr_en) begin
            buf_full <= 1'b1;
            buf_data <= wr_data;
        end else if (load) begin
            buf_full <= 1'b0;
        end
    end

    // R1: a transfer without a concurrent write empties the buffer
    p_empty_after_load_r1: assert property (@(posedge clk) disable iff (rst)
        (load && !wr_en) |=> !buf_full);

    // R10: a write always leaves the buffer full, even in a transfer cycle
    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> buf_full);

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import async_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   buf_full,
    input  frame_t next_frame,
    output logic   load,
    output logic   active,
    output logic   line
);

    logic [FRAME_W-1:0] sh;
    logic [LEN_W-1:0]   bits_left;
    logic [CNT_W-1:0]   tick_cnt;
    logic               short_r;
    logic               last_bit;
    logic [CNT_W-1:0]   bit_end_cnt;
    logic               bit_done;
    logic               frame_end;

    always_comb begin
        last_bit    = (bits_left == LEN_W'(1));
        bit_end_cnt = (last_bit && short_r) ? CNT_W'(SHORT_TICKS - 1)
                                            : CNT_W'(TICKS_PER_BIT - 1);
        bit_done    = active && tick && (tick_cnt == bit_end_cnt);
        frame_end   = bit_done && last_bit;
        load        = buf_full && (!active || frame_end);
        line        = active ? sh[0] : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '1;
            bits_left <= '0;
            tick_cnt  <= '0;
            short_r   <= 1'b0;
            active    <= 1'b0;
        end else if (load) begin
            sh        <= next_frame.bits;
            bits_left <= next_frame.nbits;
            tick_cnt  <= '0;
            short_r   <= next_frame.short_last;
            active    <= 1'b1;
        end else if (bit_done) begin
            sh        <= {1'b1, sh[FRAME_W-1:1]};
            bits_left <= bits_left - LEN_W'(1);
            tick_cnt  <= '0;
            if (last_bit) active <= 1'b0;
        end else if (active && tick) begin
            tick_cnt  <= tick_cnt + CNT_W'(1);
        end
    end

    // R2: every frame opens with a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> !line);

    // R6: the busy flag only drops on a baud tick
    p_busy_ends_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(tick));

    // R8: a shortened final stop bit never counts beyond its length
    p_short_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (active && short_r && last_bit) |-> (tick_cnt <= CNT_W'(SHORT_TICKS - 1)));

    // R9: a queued byte starts on the cycle after the previous frame ends
    p_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
        (frame_end && buf_full) |=> (active && !line));

endmodule

// File: rtl/async_tx.sv
module async_tx
    import async_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_hi,
    input  logic       cfg_bit9_par_lo,
    input  logic       cfg_two_stop,
    input  logic       cfg_short_stop,
    input  logic       irq_en,
    input  logic       rx_pin,
    output logic       txd,
    output logic       rx_to_rcvr,
    output logic       buf_empty,
    output logic       sending,
    output logic       tx_irq
);

    tx_cfg_t           cfg;
    frame_t            next_frame;
    logic              buf_full;
    logic [BYTE_W-1:0] buf_data;
    logic              load;
    logic              line;
    logic              loopback;

    always_comb begin
        cfg.len            = char_len_e'(cfg_len);
        cfg.par_en         = cfg_par_en;
        cfg.par_hi         = cfg_par_hi;
        cfg.bit9_or_par_lo = cfg_bit9_par_lo;
        cfg.two_stop       = cfg_two_stop;
        cfg.short_stop     = cfg_short_stop;
        next_frame         = build_frame(cfg, buf_data);
        loopback           = (cfg.len == LEN9_LOOP);
    end

    tx_holding u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .load     (load),
        .buf_full (buf_full),
        .buf_data (buf_data)
    );

    tx_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .tick       (baud_tick),
        .buf_full   (buf_full),
        .next_frame (next_frame),
        .load       (load),
        .active     (sending),
        .line       (line)
    );

    assign txd        = loopback ? 1'b1 : line;
    assign rx_to_rcvr = loopback ? line : rx_pin;
    assign buf_empty  = !buf_full;
    assign tx_irq     = irq_en && buf_empty;

    // R11: while looped back, the pin stays idle during frames
    p_loop_pin_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (loopback && sending) |-> txd);

    // R12: no interrupt while a byte waits in the buffer
    p_no_irq_when_full_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_en) |=> !tx_irq);

endmodule

// File: tb/async_tx_test.sv
`timescale 1ns/1ps
module async_tx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] cfg_len = 2'b00;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_hi = 1'b0;
    logic       cfg_bit9_par_lo = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_short_stop = 1'b0;
    logic       irq_en = 1'b0;
    logic       rx_pin = 1'b1;
    logic       txd, rx_to_rcvr, buf_empty, sending, tx_irq;

    int    vectors = 0;
    int    errors  = 0;
    int    cycles  = 0;
    string req_tag = "R1";
    bit    done    = 0;

    always #4 clk = ~clk;   // 125 MHz

    async_tx uut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_hi(cfg_par_hi),
        .cfg_bit9_par_lo(cfg_bit9_par_lo), .cfg_two_stop(cfg_two_stop),
        .cfg_short_stop(cfg_short_stop), .irq_en(irq_en), .rx_pin(rx_pin),
        .txd(txd), .rx_to_rcvr(rx_to_rcvr), .buf_empty(buf_empty),
        .sending(sending), .tx_irq(tx_irq)
    );

    // baud tick: one pulse every third clock
    int tick_div = 0;
    always @(posedge clk) begin
        #1;
        tick_div  = (tick_div == 2) ? 0 : tick_div + 1;
        baud_tick = (tick_div == 0);
    end

    // behavioural reference model
    bit         mq[$];
    int         mtick  = 0;
    bit         mshort = 0;
    bit         mact   = 0;
    bit         mfull  = 0;
    logic [7:0] mbuf   = '0;

    task automatic model_build();
        int nd;
        int ones;
        bit p;
        mq.delete();
        mq.push_back(1'b0);
        nd = (cfg_len == 2'b01) ? 7 : 8;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            mq.push_back(mbuf[i]);
            if (mbuf[i]) ones++;
        end
        if (cfg_len[1]) begin
            mq.push_back(cfg_bit9_par_lo);
        end else if (cfg_par_en) begin
            case ({cfg_par_hi, cfg_bit9_par_lo})
                2'b00: p = (ones % 2 == 0);
                2'b01: p = (ones % 2 == 1);
                2'b10: p = 1'b1;
                default: p = 1'b0;
            endcase
            mq.push_back(p);
        end
        mq.push_back(1'b1);
        if (cfg_two_stop) mq.push_back(1'b1);
        mshort = cfg_short_stop;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            mq.delete();
            mact = 0; mfull = 0; mtick = 0; mshort = 0;
        end else begin
            bit was_act;
            bit fe;
            int lim;
            was_act = mact;
            fe = 0;
            if (mact && baud_tick) begin
                lim = (mq.size() == 1 && mshort) ? 13 : 15;
                if (mtick == lim) begin
                    void'(mq.pop_front());
                    mtick = 0;
                    if (mq.size() == 0) begin mact = 0; fe = 1; end
                end else begin
                    mtick++;
                end
            end
            if (mfull && (!was_act || fe)) begin
                model_build();
                mact = 1; mtick = 0; mfull = 0;
            end
            if (wr_en) begin mfull = 1; mbuf = wr_data; end
        end
    end

    task automatic check1(string what, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", req_tag, what, act, exp, cycles);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic ln, lp;
            ln = mact ? mq[0] : 1'b1;
            lp = (cfg_len == 2'b11);
            check1("txd", txd, lp ? 1'b1 : ln);
            check1("rx_to_rcvr", rx_to_rcvr, lp ? ln : rx_pin);
            check1("buf_empty", buf_empty, !mfull);
            check1("sending", sending, mact);
            check1("tx_irq", tx_irq, irq_en && !mfull);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_byte(logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        while ((mact || mfull) && guard < 5000) begin
            @(posedge clk); guard++;
        end
        step(5);
    endtask

    task automatic set_cfg(logic [1:0] len, logic pe, logic ph, logic pl, logic two, logic shrt);
        @(posedge clk); #1;
        cfg_len = len; cfg_par_en = pe; cfg_par_hi = ph; cfg_bit9_par_lo = pl;
        cfg_two_stop = two; cfg_short_stop = shrt;
    endtask

    // watchdog
    initial begin
        wait (cycles > 150000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1: reset state, checked directly as well as by the model
        req_tag = "R1";
        check1("reset buf_empty", buf_empty, 1'b1);
        check1("reset sending", sending, 1'b0);
        check1("reset txd", txd, 1'b1);
        step(4);

        req_tag = "R12";
        irq_en = 1'b1;
        step(3);
        check1("irq when empty", tx_irq, 1'b1);

        req_tag = "R2";
        set_cfg(2'b00, 0, 0, 0, 0, 0);
        write_byte(8'hA5); wait_idle();

        req_tag = "R3";
        set_cfg(2'b01, 0, 0, 0, 0, 0);
        write_byte(8'hC3); wait_idle();

        req_tag = "R5";
        for (int k = 0; k < 4; k++) begin
            set_cfg(2'b01, 1, k[1], k[0], 0, 0);
            write_byte(8'h5B); wait_idle();
            set_cfg(2'b00, 1, k[1], k[0], 0, 0);
            write_byte(8'h96); wait_idle();
        end

        req_tag = "R4";
        set_cfg(2'b10, 1, 0, 1, 0, 0);
        write_byte(8'h3C); wait_idle();
        set_cfg(2'b10, 1, 1, 0, 0, 0);
        write_byte(8'hFF); wait_idle();

        req_tag = "R7";
        set_cfg(2'b00, 0, 0, 0, 1, 0);
        write_byte(8'h81); wait_idle();

        req_tag = "R8";
        set_cfg(2'b00, 0, 0, 0, 0, 1);
        write_byte(8'h7E); wait_idle();
        set_cfg(2'b01, 1, 0, 1, 1, 1);
        write_byte(8'h0F); wait_idle();

        req_tag = "R6";
        irq_en = 1'b0;
        set_cfg(2'b00, 0, 0, 0, 0, 0);
        write_byte(8'h11);
        step(100);
        write_byte(8'h22);
        wait_idle();

        req_tag = "R9";
        set_cfg(2'b00, 1, 0, 0, 0, 1);
        write_byte(8'hE7);
        step(200);
        write_byte(8'h18);
        step(50);
        write_byte(8'hAA);
        wait_idle();

        req_tag = "R10";
        irq_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = 8'h4D;
        @(posedge clk); #1;
        wr_data = 8'hB2;
        @(posedge clk); #1;
        wr_en = 1'b0;
        wait_idle();

        req_tag = "R11";
        set_cfg(2'b00, 0, 0, 0, 0, 0);
        rx_pin = 1'b0; step(4); rx_pin = 1'b1; step(4);
        set_cfg(2'b11, 1, 0, 1, 0, 0);
        write_byte(8'h69);
        step(30); rx_pin = 1'b0; step(30); rx_pin = 1'b1;
        wait_idle();

        req_tag = "R12";
        set_cfg(2'b00, 0, 0, 0, 0, 0);
        write_byte(8'h33);
        irq_en = 1'b0; step(20); irq_en = 1'b1;
        wait_idle();
        check1("irq after drain", tx_irq, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule